// File: doc/BRIEF.md
# Branch-and-Link Execute Unit

This unit executes immediate-form subroutine calls for a core with two instruction sets. The wide set uses fixed 32-bit words. The compact set uses pairs of 16-bit halfwords. Each call is offered as one 32-bit word on a valid/ready input. For the compact set, the first halfword sits in bits [31:16] and the second in bits [15:0]. With the word come the read-PC value, a condition-passed flag and two flags that describe IT-block position. Which set the word is decoded in depends on the unit's own registered instruction-set state.

For each accepted call the unit forms a sign-extended offset. There are four encodings, each with its own immediate layout. From that offset and the PC it computes the branch target and the link value. On the next cycle it pulses a branch strobe and a link-write strobe. When the call is an exchanging form, it also flips the instruction-set state. Undefined and unpredictable encodings raise one-cycle flags.

Back-pressure: `in_ready` is held high, so the unit accepts a word on every cycle in which `in_valid` is high. The outputs are one-cycle pulses and have no handshake, so the consumer must take them in the cycle they appear. The read-PC must be the instruction address plus 8 in the wide set and plus 4 in the compact set.

Top module: `bl_exec_unit`

## Requirements
- R1: After reset, `br_valid`, `lr_we`, `undef_flag` and `unpred_flag` are 0 and `isa_state` is 0, which denotes the wide set (1 denotes the compact set).
- R2: In the wide set, a word is a plain call when bits [31:28] are not 1111 and bits [27:24] are 1011. Its offset is sign-extend({bits[23:0], 2'b00}). The target is PC + offset and the state stays wide.
- R3: In the wide set, a word is an exchanging call when bits [31:28] are 1111 and bits [27:25] are 101. Its offset is sign-extend({bits[23:0], bit24, 1'b0}). The target is PC + offset and the state becomes compact. This form executes even when `cond_pass` is 0.
- R4: In the compact set, with first halfword hw1 = bits[31:16] and second halfword hw2 = bits[15:0], a word is a plain call when hw1[15:11] = 11110, hw2[15:14] = 11 and hw2[12] = 1. Let S = hw1[10], J1 = hw2[13], J2 = hw2[11], I1 = ~(J1^S) and I2 = ~(J2^S). The offset is sign-extend({S, I1, I2, hw1[9:0], hw2[10:0], 1'b0}). The target is PC + offset and the state stays compact.
- R5: In the compact set, the same word with hw2[12] = 0 and hw2[0] = 0 is an exchanging call. Its offset is sign-extend({S, I1, I2, hw1[9:0], hw2[10:1], 2'b00}). The target is (PC with bits [1:0] cleared) + offset and the state becomes wide.
- R6: A compact exchanging word with hw2[0] = 1 raises `undef_flag` and produces no branch, no link write and no state change.
- R7: A compact call accepted with `in_it` = 1 and `last_in_it` = 0 raises `unpred_flag`. The call otherwise behaves as R4/R5 describe.
- R8: Except for the R3 form, a call accepted with `cond_pass` = 0 produces no branch, no link write and no state change.
- R9: The link value is PC − 4 when the call executes in the wide set. It is {PC[31:1], 1'b1} when the call executes in the compact set.
- R10: A word that matches none of the call encodings for the current set produces no strobe and no flag.
- R11: Results appear in the cycle after the word is accepted, and `br_valid` and `lr_we` pulse together for one cycle. Calls on consecutive cycles each produce their own result with no bubble.
- R12: `isa_state` changes only in a cycle in which `br_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Always 1; unit never stalls |
| instr | input | 32 | Wide word, or halfword pair with the first halfword in [31:16] |
| pc | input | ADDR_W | Read-PC of the instruction |
| cond_pass | input | 1 | Condition check passed |
| in_it | input | 1 | Instruction is inside an IT block |
| last_in_it | input | 1 | Instruction is the last one of its IT block |
| br_valid | output | 1 | One-cycle branch strobe |
| br_target | output | ADDR_W | Branch target address |
| lr_we | output | 1 | One-cycle link write strobe |
| lr_value | output | ADDR_W | Link value |
| isa_state | output | 1 | 0 = wide set, 1 = compact set |
| undef_flag | output | 1 | Undefined encoding seen |
| unpred_flag | output | 1 | Unpredictable IT placement seen |

## Verification
The bench builds the unit with the default ADDR_W of 32. With that width, the full 26-bit wide-set offsets and the 25-bit compact offsets sign-extend into real 32-bit address arithmetic. This makes negative offsets, the large I1/I2-driven jumps and the PC alignment of the compact exchanging call all observable at the ports. A sequence of calls walks the state register through both instruction sets, so the link rule and the target-base rule of each set are exercised in turn.

// File: rtl/bl_exec_pkg.sv
package bl_exec_pkg;
  // Raw offset width before sign extension (widest encoding).
  localparam int OFF_W = 26;

  typedef enum logic {
    ISA_WIDE = 1'b0,
    ISA_HALF = 1'b1
  } isa_e;

  typedef struct packed {
    logic             hit;     // word is one of the call encodings
    logic             undef;   // encoding is undefined
    logic             unpred;  // IT placement is unpredictable
    logic             uncond;  // executes regardless of condition
    isa_e             tgt_isa; // instruction set after the branch
    logic [OFF_W-1:0] off;     // signed raw offset
  } call_dec_t;
endpackage

// File: rtl/bl_wide_decode.sv
module bl_wide_decode
  import bl_exec_pkg::*;
(
  input  logic [31:0] instr,
  output call_dec_t   dec
);
  logic [3:0] cond_f;
  logic       is_plain;
  logic       is_exch;

  assign cond_f   = instr[31:28];
  assign is_plain = (cond_f != 4'hF) && (instr[27:24] == 4'b1011);
  assign is_exch  = (cond_f == 4'hF) && (instr[27:25] == 3'b101);

  always_comb begin
    dec         = '0;
    dec.hit     = is_plain | is_exch;
    dec.uncond  = is_exch;
    dec.tgt_isa = is_exch ? ISA_HALF : ISA_WIDE;
    if (is_exch) dec.off = {instr[23:0], instr[24], 1'b0};
    else         dec.off = {instr[23:0], 2'b00};
  end
endmodule

// File: rtl/bl_half_decode.sv
module bl_half_decode
  import bl_exec_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        in_it,
  input  logic        last_in_it,
  output call_dec_t   dec
);
  logic [15:0] hw1;
  logic [15:0] hw2;
  logic        sgn;
  logic        i1;
  logic        i2;
  logic        base_ok;
  logic        is_plain;
  logic        is_exch;

  assign hw1      = instr[31:16];
  assign hw2      = instr[15:0];
  assign sgn      = hw1[10];
  assign i1       = ~(hw2[13] ^ sgn);
  assign i2       = ~(hw2[11] ^ sgn);
  assign base_ok  = (hw1[15:11] == 5'b11110) && (hw2[15:14] == 2'b11);
  assign is_plain = base_ok && hw2[12];
  assign is_exch  = base_ok && !hw2[12];

  always_comb begin
    dec         = '0;
    dec.hit     = is_plain | is_exch;
    dec.undef   = is_exch && hw2[0];
    dec.unpred  = (is_plain | is_exch) && in_it && !last_in_it;
    dec.uncond  = 1'b0;
    dec.tgt_isa = is_exch ? ISA_WIDE : ISA_HALF;
    if (is_exch) dec.off = {sgn, sgn, i1, i2, hw1[9:0], hw2[10:1], 2'b00};
    else         dec.off = {sgn, sgn, i1, i2, hw1[9:0], hw2[10:0], 1'b0};
  end
endmodule

// File: rtl/bl_addr_gen.sv
module bl_addr_gen
  import bl_exec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  isa_e              cur_isa,
  input  isa_e              tgt_isa,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] link
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_x;
  logic [ADDR_W-1:0] base;

  generate
    if (EXT_W > 0) begin : g_sext
      assign off_x = {{EXT_W{off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_x = off[ADDR_W-1:0];
    end
  endgenerate

  assign base   = (tgt_isa == ISA_WIDE) ? {pc[ADDR_W-1:2], 2'b00} : pc;
  assign target = base + off_x;
  assign link   = (cur_isa == ISA_WIDE) ? (pc - ADDR_W'(4))
                                        : {pc[ADDR_W-1:1], 1'b1};
endmodule

// File: rtl/bl_exec_unit.sv
module bl_exec_unit
  import bl_exec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] pc,
  input  logic              cond_pass,
  input  logic              in_it,
  input  logic              last_in_it,
  output logic              br_valid,
  output logic [ADDR_W-1:0] br_target,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_value,
  output logic              isa_state,
  output logic              undef_flag,
  output logic              unpred_flag
);
  isa_e              isa_q;
  call_dec_t         wide_dec;
  call_dec_t         half_dec;
  call_dec_t         dec;
  logic [ADDR_W-1:0] tgt_c;
  logic [ADDR_W-1:0] link_c;
  logic              take;

  bl_wide_decode u_wide (
    .instr (instr),
    .dec   (wide_dec)
  );

  bl_half_decode u_half (
    .instr      (instr),
    .in_it      (in_it),
    .last_in_it (last_in_it),
    .dec        (half_dec)
  );

  assign dec = (isa_q == ISA_HALF) ? half_dec : wide_dec;

  bl_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .pc      (pc),
    .cur_isa (isa_q),
    .tgt_isa (dec.tgt_isa),
    .off     (dec.off),
    .target  (tgt_c),
    .link    (link_c)
  );

  assign in_ready = 1'b1;
  assign take     = in_valid && dec.hit && !dec.undef && (cond_pass || dec.uncond);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isa_q       <= ISA_WIDE;
      br_valid    <= 1'b0;
      lr_we       <= 1'b0;
      br_target   <= '0;
      lr_value    <= '0;
      undef_flag  <= 1'b0;
      unpred_flag <= 1'b0;
    end else begin
      br_valid    <= take;
      lr_we       <= take;
      undef_flag  <= in_valid && dec.hit && dec.undef;
      unpred_flag <= in_valid && dec.hit && dec.unpred;
      if (take) begin
        br_target <= tgt_c;
        lr_value  <= link_c;
        isa_q     <= dec.tgt_isa;
      end
    end
  end

  assign isa_state = isa_q;
endmodule

// File: rtl/bl_exec_unit_chk.sv
module bl_exec_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              br_valid,
  input logic [ADDR_W-1:0] br_target,
  input logic              lr_we,
  input logic [ADDR_W-1:0] lr_value,
  input logic              isa_state,
  input logic              undef_flag,
  input logic              unpred_flag
);
  // R11
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid == lr_we);

  // R6
  undef_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> !br_valid && !lr_we);

  // R12
  isa_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(isa_state) |-> br_valid);

  // R9
  half_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we && $past(isa_state) |-> lr_value[0]);

  // R5
  wide_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !isa_state |-> br_target[1:0] == 2'b00);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !br_valid && !undef_flag && !unpred_flag);
endmodule

bind bl_exec_unit bl_exec_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .br_valid    (br_valid),
  .br_target   (br_target),
  .lr_we       (lr_we),
  .lr_value    (lr_value),
  .isa_state   (isa_state),
  .undef_flag  (undef_flag),
  .unpred_flag (unpred_flag)
);

// File: tb/bl_exec_unit_tb_top.sv
`timescale 1ns/1ps
module bl_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic        cond_pass = 1'b1;
  logic        in_it = 1'b0;
  logic        last_in_it = 1'b0;
  logic        br_valid;
  logic [31:0] br_target;
  logic        lr_we;
  logic [31:0] lr_value;
  logic        isa_state;
  logic        undef_flag;
  logic        unpred_flag;

  always #2.5 clk = ~clk;

  bl_exec_unit #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .pc(pc), .cond_pass(cond_pass), .in_it(in_it),
    .last_in_it(last_in_it), .br_valid(br_valid), .br_target(br_target),
    .lr_we(lr_we), .lr_value(lr_value), .isa_state(isa_state),
    .undef_flag(undef_flag), .unpred_flag(unpred_flag)
  );

  typedef struct {
    string       req;
    logic        br;
    logic [31:0] tgt;
    logic [31:0] lr;
    logic        isa;
    logic        und;
    logic        unp;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic model_isa = 1'b0;
  logic done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input string req, input logic [31:0] w,
                                 input logic [31:0] p, input logic cur,
                                 input logic c, input logic it, input logic last);
    exp_t        e;
    logic        hit = 0, unc = 0, tgt_isa = cur, und = 0;
    logic [31:0] off = '0;
    logic [15:0] a = w[31:16];
    logic [15:0] b = w[15:0];
    logic        s = a[10];
    logic        x1 = ~(b[13] ^ s);
    logic        x2 = ~(b[11] ^ s);
    e.req = req; e.unp = 1'b0;
    if (!cur) begin
      if (w[31:28] != 4'hF && w[27:24] == 4'hB) begin
        hit = 1; off = {{6{w[23]}}, w[23:0], 2'b00}; tgt_isa = 0;
      end else if (w[31:28] == 4'hF && w[27:25] == 3'b101) begin
        hit = 1; unc = 1; off = {{6{w[23]}}, w[23:0], w[24], 1'b0}; tgt_isa = 1;
      end
    end else if (a[15:11] == 5'b11110 && b[15:14] == 2'b11) begin
      hit = 1;
      e.unp = it && !last;
      if (b[12]) begin
        off = {{8{s}}, x1, x2, a[9:0], b[10:0], 1'b0}; tgt_isa = 1;
      end else begin
        und = b[0];
        off = {{8{s}}, x1, x2, a[9:0], b[10:1], 2'b00}; tgt_isa = 0;
      end
    end
    e.und = und;
    e.br  = hit && !und && (c || unc);
    e.tgt = (tgt_isa ? p : (p & 32'hFFFF_FFFC)) + off;
    e.lr  = cur ? (p | 32'h1) : (p - 32'd4);
    e.isa = e.br ? tgt_isa : cur;
    return e;
  endfunction

  task automatic send(input string req, input logic [31:0] w, input logic [31:0] p,
                      input logic c, input logic it, input logic last);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; instr = w; pc = p; cond_pass = c; in_it = it; last_in_it = last;
    e = model(req, w, p, model_isa, c, it, last);
    model_isa = e.isa;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop one expected item per accepted word
  initial begin
    forever begin
      logic cap;
      exp_t e;
      @(posedge clk);
      cap = in_valid && rst_n;
      @(negedge clk);
      if (cap && q.size() > 0) begin
        e = q.pop_front();
        chk(e.req, "br_valid", {31'b0, br_valid}, {31'b0, e.br});
        chk(e.req, "lr_we", {31'b0, lr_we}, {31'b0, e.br});
        if (e.br) begin
          chk(e.req, "br_target", br_target, e.tgt);
          chk(e.req, "lr_value R9", lr_value, e.lr);
        end
        chk(e.req, "isa_state", {31'b0, isa_state}, {31'b0, e.isa});
        chk(e.req, "undef_flag", {31'b0, undef_flag}, {31'b0, e.und});
        chk(e.req, "unpred_flag", {31'b0, unpred_flag}, {31'b0, e.unp});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "br_valid", {31'b0, br_valid}, 32'd0);
    chk("R1", "lr_we", {31'b0, lr_we}, 32'd0);
    chk("R1", "flags", {30'b0, undef_flag, unpred_flag}, 32'd0);
    chk("R1", "isa_state", {31'b0, isa_state}, 32'd0);
    chk("R1", "in_ready R11", {31'b0, in_ready}, 32'd1);

    send("R2", 32'hEB00_0010, 32'h0000_1008, 1, 0, 0);
    send("R2", 32'hEBFF_FFFE, 32'h0000_1010, 1, 0, 0); // back-to-back, R11
    send("R8", 32'hEB00_0010, 32'h0000_1018, 0, 0, 0);
    send("R10", 32'hE080_0001, 32'h0000_1020, 1, 0, 0);
    idle(2);
    send("R3", 32'hFB00_0004, 32'h0000_2008, 0, 0, 0);
    idle(1);
    send("R4", 32'hF000_F810, 32'h0000_201E, 1, 1, 1);
    send("R4", 32'hF000_D800, 32'h0000_0100, 1, 0, 0);
    send("R7", 32'hF7FF_FFFF, 32'h0000_3004, 1, 1, 0);
    send("R6", 32'hF000_E801, 32'h0000_3008, 1, 0, 0);
    send("R8", 32'hF000_F810, 32'h0000_300C, 0, 0, 0);
    send("R10", 32'h46C0_46C0, 32'h0000_3010, 1, 0, 0);
    send("R5", 32'hF000_E80A, 32'h0000_3006, 1, 0, 0);
    send("R12", 32'hEB00_0001, 32'h0000_4008, 1, 0, 0);
    idle(3);
    // R10 no strobe while idle
    chk("R10", "idle br_valid", {31'b0, br_valid}, 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule